// File: doc/BRIEF.md
# Refresh Interval Timer with Memory-Mode Select

This block counts prescaled clock ticks up to a programmable compare value and marks each wrap with a status flag. Two mode bits choose what a wrap does. It can raise a refresh request toward a memory controller that serves a DRAM region. It can raise a refresh request for a pseudo-static RAM region. With neither mode selected, it runs as a general interval timer whose only visible effect is the flag and its interrupt.

Software reaches four byte registers through a simple bus with read and write strobes. The read data is combinational. A refresh request stays raised until the controller acknowledges it. When a compare match arrives while a request is still waiting, the match is recorded in a sticky overrun bit and is not queued. In DRAM mode, a write-strobe style bit and a 2-bit column addressing field pass straight out to the memory controller.

Top module: `refresh_tick_timer`

## Requirements
- R1: After reset every register reads 0 and every output is low.
- R2: Address 0 is the mode register. Bit0 is the DRAM enable and bit1 is the PSRAM enable. Bits 1:0 = 01 gives DRAM mode (`dram_sel`=1), 10 gives PSRAM mode (`psram_sel`=1), and 00 or 11 gives interval-timer mode, in which no refresh request is ever raised.
- R3: Bits 2:0 of address 1 select the count clock. Codes 1..7 divide the clock by 2, 8, 32, 128, 512, 2048 and 4096. Code 0 holds the counter still.
- R4: On each count tick the counter at address 3 increments. A tick that finds the counter equal to the compare value at address 2 clears it to 0. The match period is therefore (compare+1) ticks.
- R5: The flag (address 1 bit7) is set when a tick brings the counter to the compare value. Software clears it only by writing bit7=0 after a read of address 1 that returned bit7=1. Writing 1 has no effect. A set in the same cycle as the clear wins.
- R6: `tmr_irq` is high exactly while the flag is set and address 1 bit6 (interrupt enable) is 1.
- R7: In DRAM or PSRAM mode, with mode bit2 (refresh insert enable) set, a match raises `rfsh_req`. The request stays high until a cycle with `rfsh_ack` high. With bit2 clear, no request is raised.
- R8: A match that would raise a request while one is still pending and unacknowledged sets mode bit7 (overrun). Writing mode bit7=0 clears it.
- R9: `rfsh_pin` follows `rfsh_req` only when mode bit3 (pin enable) is set and a refresh mode is active. In interval-timer mode it stays low.
- R10: In DRAM mode `wr_style_o` carries mode bit4 and `col_mode_o` carries mode bits 6:5. In any other mode both are 0.
- R11: Compare and counter values written over the bus read back unchanged while the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational) |
| rfsh_ack | input | 1 | Refresh acknowledge from the memory controller |
| rfsh_req | output | 1 | Refresh request |
| rfsh_pin | output | 1 | External refresh strobe |
| tmr_irq | output | 1 | Compare-match interrupt |
| dram_sel | output | 1 | DRAM mode active |
| psram_sel | output | 1 | PSRAM mode active |
| wr_style_o | output | 1 | Write-strobe style select (DRAM only) |
| col_mode_o | output | 2 | Column addressing mode (DRAM only) |

## Verification
The bench measures the cycle distance between successive refresh requests for random compare values and divider codes, and a directed run covers the slowest divider. A wrong wrap point or a wrong divider tap shows up there as an interval that is off by a tick or by a factor. Directed cases check the flag-clear protocol: a design that lets a blind write of 0 clear the flag would lose an interrupt. They also check that setting both mode bits yields no requests, and that a pending request does not drive the pin once timer mode is selected. Withholding the acknowledge across several matches must set the overrun bit, so a design that queued or dropped matches without recording them is caught.

// File: rtl/refresh_tick_timer.sv
module refresh_tick_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rfsh_ack,
  output logic          rfsh_req,
  output logic          rfsh_pin,
  output logic          tmr_irq,
  output logic          dram_sel,
  output logic          psram_sel,
  output logic          wr_style_o,
  output logic [1:0]    col_mode_o
);
  localparam int PW = 12;

  logic          dram_en, psram_en, ins_en, pin_en, style, ovf;
  logic [1:0]    col;
  logic [2:0]    cks;
  logic          ie, flag, armed, req;
  logic [DW-1:0] cmp, cnt;
  logic [PW-1:0] presc, mask;

  wire wr_mode = bus_wr && bus_addr == 2'd0;
  wire wr_tcs  = bus_wr && bus_addr == 2'd1;
  wire wr_cmp  = bus_wr && bus_addr == 2'd2;
  wire wr_cnt  = bus_wr && bus_addr == 2'd3;
  wire rd_tcs  = bus_rd && bus_addr == 2'd1;

  wire dram_mode  = dram_en & ~psram_en;
  wire psram_mode = psram_en & ~dram_en;
  wire rf_mode    = dram_mode | psram_mode;

  always_comb begin
    case (cks)
      3'd1:    mask = 12'h001;
      3'd2:    mask = 12'h007;
      3'd3:    mask = 12'h01F;
      3'd4:    mask = 12'h07F;
      3'd5:    mask = 12'h1FF;
      3'd6:    mask = 12'h7FF;
      3'd7:    mask = 12'hFFF;
      default: mask = 12'h000;
    endcase
  end

  wire          tick     = (cks != 3'd0) && ((presc & mask) == mask);
  wire [DW-1:0] cnt_nxt  = (cnt == cmp) ? '0 : cnt + 1'b1;
  wire          hit      = tick && !wr_cnt && (cnt_nxt == cmp);
  wire          new_req  = hit && rf_mode && ins_en;
  wire          flag_clr = wr_tcs && !bus_wdata[7] && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      cnt   <= '0;
      cmp   <= '0;
      {col, style, pin_en, ins_en, psram_en, dram_en} <= '0;
      ovf   <= 1'b0;
      cks   <= '0;
      ie    <= 1'b0;
      flag  <= 1'b0;
      armed <= 1'b0;
      req   <= 1'b0;
    end else begin
      presc <= presc + 1'b1;
      if (wr_cnt)      cnt <= bus_wdata;
      else if (tick)   cnt <= cnt_nxt;
      if (wr_cmp)      cmp <= bus_wdata;
      if (wr_mode)     {col, style, pin_en, ins_en, psram_en, dram_en} <= bus_wdata[6:0];
      if (new_req && req && !rfsh_ack) ovf <= 1'b1;
      else if (wr_mode && !bus_wdata[7]) ovf <= 1'b0;
      if (wr_tcs) begin
        cks <= bus_wdata[2:0];
        ie  <= bus_wdata[6];
      end
      if (hit)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (flag_clr)            armed <= 1'b0;
      else if (rd_tcs && flag) armed <= 1'b1;
      req <= (req & ~rfsh_ack) | new_req;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0:    bus_rdata[7:0] = {ovf, col, style, pin_en, ins_en, psram_en, dram_en};
      2'd1:    bus_rdata[7:0] = {flag, ie, 3'b000, cks};
      2'd2:    bus_rdata = cmp;
      default: bus_rdata = cnt;
    endcase
  end

  assign rfsh_req   = req;
  assign rfsh_pin   = req & pin_en & rf_mode;
  assign tmr_irq    = flag & ie;
  assign dram_sel   = dram_mode;
  assign psram_sel  = psram_mode;
  assign wr_style_o = dram_mode & style;
  assign col_mode_o = dram_mode ? col : 2'b00;

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cks == 3'd0 && !wr_cnt) |=> $stable(cnt)); // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && cnt == cmp) |=> cnt == '0); // R4
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag); // R5
  AST_NO_REQ_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_mode |=> !$rose(rfsh_req)); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && !rfsh_ack) |=> rfsh_req); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (new_req && rfsh_req && !rfsh_ack) |=> ovf); // R8
endmodule

// File: tb/refresh_tick_timer_tb_top.sv
module refresh_tick_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_wr = 0, bus_rd = 0, rfsh_ack = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       rfsh_req, rfsh_pin, tmr_irq, dram_sel, psram_sel, wr_style_o;
  logic [1:0] col_mode_o;
  int checks = 0, fails = 0, cyc = 0;

  refresh_tick_timer #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rfsh_ack(rfsh_ack), .rfsh_req(rfsh_req),
    .rfsh_pin(rfsh_pin), .tmr_irq(tmr_irq), .dram_sel(dram_sel), .psram_sel(psram_sel),
    .wr_style_o(wr_style_o), .col_mode_o(col_mode_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int exp_period(int code, int c);
    int sh[8] = '{0, 1, 3, 5, 7, 9, 11, 12};
    return (c + 1) << sh[code];
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!rfsh_req && n < 40000);
    rfsh_ack = 1; @(negedge clk); rfsh_ack = 0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); rfsh_ack = 1; @(negedge clk); rfsh_ack = 0;
  endtask

  task automatic watch_no_req(int n, string r);
    bit seen = 0;
    repeat (n) begin @(negedge clk); if (rfsh_req || rfsh_pin) seen = 1; end
    chk(!seen, r, seen, 0);
  endtask

  task automatic measure(logic [7:0] mode, int code, int c);
    int n;
    wr(0, mode); wr(1, 8'h80 | 8'(code)); wr(2, 8'(c)); wr(3, 0);
    wait_req(n);
    wait_req(n);
    chk(n + 1 == exp_period(code, c), "R4/R3/R7 period", n + 1, exp_period(code, c));
  endtask

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk(d == 0, "R1 reg reset", d, 0);
    end
    chk({rfsh_req, rfsh_pin, tmr_irq, dram_sel, psram_sel, wr_style_o, col_mode_o} == 0,
        "R1 outputs", {rfsh_req, rfsh_pin, tmr_irq, dram_sel, psram_sel, wr_style_o, col_mode_o}, 0);

    // R11 readback with stopped counter, R3 code 0 holds
    for (int i = 0; i < 4; i++) begin
      logic [7:0] c = 8'($urandom), v = 8'($urandom);
      wr(2, c); wr(3, v); idle(30);
      rd(2, d); chk(d == c, "R11 compare readback", d, c);
      rd(3, d); chk(d == v, "R3 R11 counter stopped", d, v);
    end

    // R5/R6 timer mode flag, irq, clear protocol
    wr(0, 8'h00); wr(2, 2); wr(3, 0); wr(1, 8'h41); idle(30);
    chk(tmr_irq == 1, "R6 irq on flag", tmr_irq, 1);
    chk(rfsh_req == 0, "R2 timer mode no request", rfsh_req, 0);
    wr(1, 8'hC0);
    wr(1, 8'h40);
    chk(tmr_irq == 1, "R5 blind clear ignored", tmr_irq, 1);
    rd(1, d); chk(d == 8'hC0, "R5 flag held", d, 8'hC0);
    wr(1, 8'h40);
    rd(1, d); chk(d == 8'h40, "R5 clear after read", d, 8'h40);
    chk(tmr_irq == 0, "R6 irq low after clear", tmr_irq, 0);

    // R2 both mode bits: timer behaviour
    wr(0, 8'h07); wr(2, 1); wr(3, 0); wr(1, 8'h01);
    chk(dram_sel == 0 && psram_sel == 0, "R2 both bits decode", {dram_sel, psram_sel}, 0);
    watch_no_req(40, "R2 both bits no request");
    rd(1, d); chk(d[7] == 1, "R4 flag set in timer mode", d[7], 1);
    wr(1, 8'h80); wr(1, 8'h00);

    // R7 insert disabled
    wr(0, 8'h01); wr(2, 1); wr(3, 0); wr(1, 8'h01);
    chk(dram_sel == 1, "R2 dram decode", dram_sel, 1);
    watch_no_req(40, "R7 insert disabled");
    wr(1, 8'h80);

    // R10 passthrough
    wr(0, 8'h75);
    chk(wr_style_o == 1 && col_mode_o == 2'd3, "R10 dram passthrough", {wr_style_o, col_mode_o}, 7);
    wr(0, 8'h76);
    chk(psram_sel == 1 && wr_style_o == 0 && col_mode_o == 0, "R10 psram masks passthrough",
        {psram_sel, wr_style_o, col_mode_o}, 4);

    // R7/R8 overrun
    wr(0, 8'h05); wr(2, 1); wr(3, 0); wr(1, 8'h01); idle(24);
    chk(rfsh_req == 1, "R7 request held without ack", rfsh_req, 1);
    rd(0, d); chk(d[7] == 1, "R8 overrun set", d[7], 1);
    wr(1, 8'h80); ack_pulse();
    chk(rfsh_req == 0, "R7 ack drops request", rfsh_req, 0);
    wr(0, 8'h05); rd(0, d); chk(d == 8'h05, "R8 overrun cleared", d, 8'h05);

    // R9 pin gating
    wr(0, 8'h0D); wr(3, 0); wr(1, 8'h81);
    n = 0;
    do begin @(negedge clk); n++; end while (!rfsh_req && n < 100);
    chk(rfsh_pin == 1, "R9 pin follows request", rfsh_pin, 1);
    wr(1, 8'h80); wr(0, 8'h0C);
    chk(rfsh_req == 1 && rfsh_pin == 0, "R9 pin low in timer mode", {rfsh_req, rfsh_pin}, 2);
    ack_pulse();

    // R3/R4/R7 random intervals
    for (int i = 0; i < 8; i++) begin
      int code = $urandom_range(1, 4);
      int c = $urandom_range(1, 10);
      measure(($urandom_range(0, 1) != 0) ? 8'h05 : 8'h06, code, c);
    end
    measure(8'h06, 5, 2);
    measure(8'h05, 6, 2);
    measure(8'h05, 7, 1);
    measure(8'h05, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule